// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the addresses of a four-beat memory burst. A controller raises `load_i` when an address-status strobe begins a cycle. The block then captures the external base address and the ordering mode. After that, each cycle with `adv_i` high steps to the next beat. A cycle with `adv_i` low holds the present beat, which suspends the burst. Only the two least-significant address bits move. The upper bits keep the value that was loaded.

Two orderings are offered, and both run from one shared 2-bit beat counter:

- **Linear** (`mode_i` = 0 at load): the low bits equal start plus beat, modulo 4.
- **Interleaved** (`mode_i` = 1 at load): the low bits equal start XOR beat.

After the fourth beat the counter returns to 0, so the address goes back to the starting address and the burst continues for as long as advance stays high.

A small state machine tracks the burst:

- **States:** `ST_IDLE` (nothing loaded since reset), `ST_STEP` (the last edge loaded or advanced) and `ST_HOLD` (the last edge held).
- **Transitions:**
  - any state → `ST_STEP` on load;
  - `ST_STEP`/`ST_HOLD` → `ST_STEP` on advance;
  - `ST_STEP`/`ST_HOLD` → `ST_HOLD` when neither load nor advance is present;
  - `ST_IDLE` stays in `ST_IDLE` without a load.

All outputs come straight from registers. Each output shows its new value in the cycle that follows the clock edge which sampled the input.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is active and after it is released, `addr_o` is 0 and `beat_o` is 0, until the first load.
- R2: A load edge makes `addr_o` equal to `base_i` and `beat_o` equal to 0 from the next cycle.
- R3: In a burst loaded with `mode_i`=0, the low two bits of `addr_o` equal (start + `beat_o`) mod 4. Here start is the value of `base_i[1:0]` at load.
- R4: In a burst loaded with `mode_i`=1, the low two bits of `addr_o` equal start XOR `beat_o`.
- R5: Bits above bit 1 of `addr_o` remain equal to the loaded `base_i` bits for the whole burst.
- R6: An advance edge without load increments `beat_o` by 1. From beat 3 it wraps to beat 0, so `addr_o` returns to the starting address.
- R7: An edge with `adv_i`=0 and `load_i`=0 leaves `addr_o` and `beat_o` unchanged.
- R8: A load takes priority over an advance in the same edge, and a load during a burst restarts the burst at beat 0 from the new base.
- R9: `mode_i` is sampled only at load. Changing it during a burst does not change the address order.
- R10: Advance edges before the first load after reset have no effect; `addr_o` and `beat_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start a burst from `base_i` |
| adv_i | input | 1 | Step to the next beat (high) or hold (low) |
| mode_i | input | 1 | Ordering at load: 0 linear, 1 interleaved |
| base_i | input | ADDR_W | External base address |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Current beat index |

## Verification
A fixed vector table exercises the following cases:

- a linear burst that starts at an odd offset, with a hold in the middle and a full wrap;
- an interleaved burst whose mode input toggles mid-burst;
- a load together with advance in the same edge;
- a restart in the middle of a burst.

These cases separate an adder from an XOR, catch a mode input that is not latched, and catch the wrong priority between load and advance. A directed sweep covers all four start offsets in both modes, over five advances each. It shows that the two orderings agree only where they must: at beat 0 for every start, and at beats where start + beat produces no carry. Further directed tests check the reset values, advances before any load, and a reset asserted in the middle of a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
    // number of address bits that move within a burst
    localparam int unsigned LOW_W = 2;
    localparam int unsigned BEATS = 1 << LOW_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_HOLD = 2'd2
    } burst_state_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [LOW_W-1:0] beat
);
    localparam logic [LOW_W-1:0] LAST = LOW_W'(BEATS - 1);

    logic [LOW_W-1:0] beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            beat_q <= '0;
        else if (clr)
            beat_q <= '0;
        else if (inc)
            beat_q <= beat_q + 1'b1;
    end

    assign beat = beat_q;

    // R6: the counter wraps from the last beat back to zero
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && beat_q == LAST) |=> (beat_q == '0));

    // R8: clear wins over increment
    p_clr_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> (beat_q == '0));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
(
    input  logic [LOW_W-1:0] start,
    input  logic [LOW_W-1:0] beat,
    input  logic             ilv,
    output logic [LOW_W-1:0] low
);
    logic [LOW_W-1:0] lin_low;
    logic [LOW_W-1:0] xor_low;

    assign lin_low = start + beat;   // modulo 2**LOW_W by width

    for (genvar b = 0; b < LOW_W; b++) begin : g_xor
        assign xor_low[b] = start[b] ^ beat[b];
    end

    assign low = ilv ? xor_low : lin_low;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int unsigned ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LOW_W-1:0]  beat_o
);
    localparam int unsigned HI_W = ADDR_W - LOW_W;

    burst_state_e state_q, state_d;

    logic [HI_W-1:0]  upper_q;
    logic [LOW_W-1:0] start_q;
    logic             ilv_q;
    logic             ctr_clr;
    logic             ctr_inc;
    logic [LOW_W-1:0] beat;
    logic [LOW_W-1:0] low;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_i) state_d = ST_STEP;
            ST_STEP,
            ST_HOLD: begin
                if (load_i || adv_i) state_d = ST_STEP;
                else                 state_d = ST_HOLD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // control outputs of the state machine
    always_comb begin
        ctr_clr = load_i;
        ctr_inc = 1'b0;
        unique case (state_q)
            ST_IDLE:          ctr_inc = 1'b0;
            ST_STEP, ST_HOLD: ctr_inc = adv_i && !load_i;
            default:          ctr_inc = 1'b0;
        endcase
    end

    // burst context captured at load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            ilv_q   <= 1'b0;
        end else if (load_i) begin
            upper_q <= base_i[ADDR_W-1:LOW_W];
            start_q <= base_i[LOW_W-1:0];
            ilv_q   <= mode_i;
        end
    end

    burst_beat_ctr u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ctr_clr),
        .inc  (ctr_inc),
        .beat (beat)
    );

    burst_order_map u_map (
        .start(start_q),
        .beat (beat),
        .ilv  (ilv_q),
        .low  (low)
    );

    assign addr_o = {upper_q, low};
    assign beat_o = beat;

    // R2: a load presents the base at beat zero on the next cycle
    p_load_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o == $past(base_i) && beat_o == '0));

    // R5: upper bits do not move without a load
    p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(addr_o[ADDR_W-1:LOW_W]));

    // R7: no load and no advance holds everything
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> ($stable(addr_o) && $stable(beat_o)));

    // R6: advance inside a burst moves the beat up by one
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && adv_i && !load_i) |=>
            (beat_o == $past(beat_o) + 1'b1));

    // R10: nothing moves before the first load
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !load_i) |=> (addr_o == '0 && beat_o == '0));
endmodule

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
    localparam int ADDR_W = 18;
    localparam int NV = 19;
    // row: load, adv, mode, base, expected addr, expected beat
    localparam logic [40:0] VEC [0:NV-1] = '{
        {1'b1, 1'b0, 1'b0, 18'h2A5C1, 18'h2A5C1, 2'd0},  // R2 linear load, start 01
        {1'b0, 1'b1, 1'b0, 18'h00000, 18'h2A5C2, 2'd1},  // R3
        {1'b0, 1'b1, 1'b0, 18'h00000, 18'h2A5C3, 2'd2},  // R3 R5
        {1'b0, 1'b0, 1'b0, 18'h11111, 18'h2A5C3, 2'd2},  // R7 hold
        {1'b0, 1'b1, 1'b0, 18'h00000, 18'h2A5C0, 2'd3},  // R3
        {1'b0, 1'b1, 1'b0, 18'h00000, 18'h2A5C1, 2'd0},  // R6 wrap
        {1'b1, 1'b0, 1'b1, 18'h3F0A6, 18'h3F0A6, 2'd0},  // R4 interleaved, start 10
        {1'b0, 1'b1, 1'b1, 18'h00000, 18'h3F0A7, 2'd1},  // R4
        {1'b0, 1'b1, 1'b0, 18'h00000, 18'h3F0A4, 2'd2},  // R9 mode changed
        {1'b0, 1'b1, 1'b0, 18'h00000, 18'h3F0A5, 2'd3},  // R9
        {1'b0, 1'b1, 1'b0, 18'h00000, 18'h3F0A6, 2'd0},  // R6 wrap
        {1'b1, 1'b1, 1'b0, 18'h01233, 18'h01233, 2'd0},  // R8 load beats advance
        {1'b0, 1'b1, 1'b0, 18'h00000, 18'h01230, 2'd1},  // R3 carry out of low bits
        {1'b1, 1'b0, 1'b1, 18'h00004, 18'h00004, 2'd0},  // R8 restart mid-burst
        {1'b0, 1'b1, 1'b1, 18'h00000, 18'h00005, 2'd1},  // R4
        {1'b0, 1'b0, 1'b1, 18'h3FFFF, 18'h00005, 2'd1},  // R7
        {1'b0, 1'b1, 1'b1, 18'h00000, 18'h00006, 2'd2},  // R4
        {1'b0, 1'b1, 1'b1, 18'h00000, 18'h00007, 2'd3},  // R4 R5
        {1'b0, 1'b1, 1'b1, 18'h00000, 18'h00004, 2'd0}   // R6
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_i = 1'b0;
    logic              adv_i = 1'b0;
    logic              mode_i = 1'b0;
    logic [ADDR_W-1:0] base_i = '0;
    logic [ADDR_W-1:0] addr_o;
    logic [1:0]        beat_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W)) u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load_i),
        .adv_i (adv_i),
        .mode_i(mode_i),
        .base_i(base_i),
        .addr_o(addr_o),
        .beat_o(beat_o)
    );

    task automatic check(input string req, input logic [ADDR_W-1:0] ea,
                         input logic [1:0] eb);
        checks++;
        if (addr_o !== ea || beat_o !== eb) begin
            errors++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     req, addr_o, beat_o, ea, eb);
        end
    endtask

    // drive on falling edge, sample at the next falling edge
    task automatic step(input logic ld, input logic ad, input logic md,
                        input logic [ADDR_W-1:0] b);
        load_i = ld; adv_i = ad; mode_i = md; base_i = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", '0, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", '0, 2'd0);

        // R10: advances before any load
        step(1'b0, 1'b1, 1'b1, 18'h2BEEF);
        check("R10 idle advance", '0, 2'd0);
        step(1'b0, 1'b1, 1'b0, 18'h13579);
        check("R10 idle advance", '0, 2'd0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][40], VEC[i][39], VEC[i][38], VEC[i][37:20]);
            check($sformatf("table row %0d (R2..R9 set)", i),
                  VEC[i][19:2], VEC[i][1:0]);
        end

        // sweep: every start offset in both orders (R3, R4, R6)
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                logic [ADDR_W-1:0] b;
                b = 18'h1C3A8 | ADDR_W'(s);
                step(1'b1, 1'b0, md[0], b);
                check(md ? "R4 sweep load" : "R3 sweep load", b, 2'd0);
                for (int n = 1; n <= 5; n++) begin
                    logic [1:0] nb, lo;
                    nb = 2'(n);
                    lo = md ? (2'(s) ^ nb) : (2'(s) + nb);
                    step(1'b0, 1'b1, ~md[0], '0);
                    check(md ? "R4 sweep" : "R3 sweep",
                          {b[ADDR_W-1:2], lo}, nb);
                end
            end
        end

        // R1: reset in the middle of a burst
        step(1'b1, 1'b0, 1'b0, 18'h0F0F2);
        step(1'b0, 1'b1, 1'b0, '0);
        check("R3 before reset", 18'h0F0F3, 2'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-burst reset", '0, 2'd0);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 1'b0, '0);
        check("R10 advance after reset", '0, 2'd0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule